// File: doc/BRIEF.md
# Deferred Halfword Register Write Combiner

This block sits between a host port that issues byte, halfword and word register accesses and a peripheral register file that only accepts whole 32-bit words. Narrow writes become a read of the containing word followed by a merged word write; narrow reads fetch the word and return the addressed lane.

Four halfwords receive special treatment. Block size (0x04) and block count (0x06) share one word, and transfer mode (0x0C) and command (0x0E) share another. Writes to the first three are kept in two internal shadow words and are not forwarded. A later write to the command halfword releases them as at most two back-to-back word writes, so the peripheral never receives two quick writes to the same word from split halfword traffic.

When the card clock is slow, each downstream word write is followed by a stall of four card-clock periods, rounded up to whole microseconds. The upstream port stays not-ready for the whole stall.

Top module: `regwr_combiner`

## Requirements
- R1: A word access (size code 2) is forwarded once to the word address, which is the access address with its two low bits cleared. up_ready is high only while no access is in progress. On a fast card clock, a word write holds up_ready low for exactly one cycle.
- R2: A byte (size code 0) or halfword (size code 1) write reads the containing word and writes back (old & ~mask) | (data << shift). Here shift is the low two address bits times eight, and mask is 0xFF or 0xFFFF at that shift. Narrow reads return the lane zero-extended in the low bits of up_rdata.
- R3: A halfword write to 0x04 or 0x06 updates the block shadow word and sets its flag. No downstream write is issued.
- R4: A halfword write to 0x0C reads word 0x0C downstream, merges into it, and stores the result in the command shadow, setting its flag. No downstream write is issued.
- R5: A halfword write to 0x0E works in two steps. First, if the block flag is set, the block shadow is written to word 0x04 and the flag is cleared. Then (command shadow with the new value in bits 31:16) is written to word 0x0C and the command flag is cleared. On a fast clock the whole sequence holds up_ready low for one cycle per write.
- R6: A halfword read of 0x0C while the command flag is set, or of 0x04/0x06 while the block flag is set, returns the shadow lane with no downstream read. All other reads fetch the word downstream.
- R7: A halfword write to 0x04/0x06 while the block flag is set merges into the block shadow without a downstream read.
- R8: Byte writes are never shadowed. They always do a downstream read-modify-write, and they leave the shadows unchanged.
- R9: Card clocks are classed as slow when card_hz <= 400000. On a slow card clock, each downstream write is followed by ceil(4e6/card_hz) microseconds of stall, or 10 us when card_hz is 0. This makes up_ready low for 1 + stall cycles per write.
- R10: Reset clears both flags and both shadow words to zero, leaves up_ready high, and drives no downstream access.
- R11: Read data comes with a one-cycle up_rvalid pulse in a cycle where up_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted when high with up_valid |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word |
| up_addr | input | ADDR_W | Byte address |
| up_wdata | input | 32 | Write data, lane value in the low bits |
| up_rdata | output | 32 | Read data, lane value in the low bits |
| up_rvalid | output | 1 | Read data valid pulse |
| card_hz | input | HZ_W | Present card clock in Hz |
| dn_valid | output | 1 | Downstream word access |
| dn_we | output | 1 | Downstream access is a write |
| dn_addr | output | ADDR_W | Downstream word address |
| dn_wdata | output | 32 | Downstream write word |
| dn_rdata | input | 32 | Downstream read word, valid the cycle after the read |

## Verification
Two functions can meet in one operation: the command write releases the block shadow and merges the command shadow, and on a slow card clock each of those two writes also starts a hold-off. The bench fills both shadows, then writes the command halfword at 400 kHz. It judges the result by the order, addresses and data of the two logged downstream writes and by the length of the up_ready low window, which must equal two writes plus two full stalls. The same flush at a fast clock and a flush with only the command shadow pending act as contrasts.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_RDW,
      ST_WR,
      ST_HOLD
   } rwc_state_e;
endpackage

// File: rtl/rwc_lane.sv
module rwc_lane
   import rwc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] new_val,
   input  logic [1:0]        size,
   input  logic [1:0]        lane,
   output logic [DATA_W-1:0] merged,
   output logic [DATA_W-1:0] extracted
);
   logic [4:0]        shift;
   logic [DATA_W-1:0] base_mask;
   logic [DATA_W-1:0] lane_mask;

   always_comb begin
      shift = {lane, 3'b000};
      if (size == SZ_BYTE) begin
         base_mask = DATA_W'(32'h0000_00FF);
      end else if (size == SZ_HALF) begin
         base_mask = DATA_W'(32'h0000_FFFF);
      end else begin
         base_mask = '1;
         shift     = 5'd0;
      end
      lane_mask = base_mask << shift;
      merged    = (old_word & ~lane_mask) | ((new_val & base_mask) << shift);
      extracted = (old_word >> shift) & base_mask;
   end
endmodule

// File: rtl/rwc_shadow.sv
module rwc_shadow #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              clear,
   output logic [DATA_W-1:0] word,
   output logic              valid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word  <= '0;
         valid <= 1'b0;
      end else if (load) begin
         word  <= din;
         valid <= 1'b1;
      end else if (clear) begin
         valid <= 1'b0;
      end
   end

   p_load_clear_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && clear));
   p_valid_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> valid);
endmodule

// File: rtl/rwc_holdoff.sv
module rwc_holdoff #(
   parameter int CYC_PER_US = 125,
   parameter int HZ_W       = 32,
   parameter int PERIODS    = 4,
   parameter int ZERO_US    = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [HZ_W-1:0] card_hz,
   output logic            busy,
   output logic            last
);
   localparam int CYC_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
   localparam int US_W  = $clog2(ZERO_US + 1);
   localparam int ACC_W = HZ_W + 2;
   localparam logic [ACC_W-1:0] TARGET = ACC_W'(PERIODS * 1000000);

   logic [CYC_W-1:0] cyc;
   logic [US_W-1:0]  us;
   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] acc_nxt;
   logic [US_W-1:0]  us_nxt;
   logic             tick;
   logic             reached;

   always_comb begin
      tick    = busy && (cyc == CYC_W'(CYC_PER_US - 1));
      acc_nxt = acc + ACC_W'(card_hz);
      us_nxt  = us + 1'b1;
      reached = (card_hz == '0) ? (us_nxt == US_W'(ZERO_US)) : (acc_nxt >= TARGET);
      last    = tick && reached;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cyc  <= '0;
         us   <= '0;
         acc  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cyc  <= '0;
         us   <= '0;
         acc  <= '0;
      end else if (busy) begin
         if (tick) begin
            cyc <= '0;
            us  <= us_nxt;
            acc <= acc_nxt;
            if (reached) busy <= 1'b0;
         end else begin
            cyc <= cyc + 1'b1;
         end
      end
   end

   p_start_when_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   p_last_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !busy);
endmodule

// File: rtl/regwr_combiner.sv
module regwr_combiner
   import rwc_pkg::*;
#(
   parameter int             ADDR_W     = 8,
   parameter int             DATA_W     = 32,
   parameter int             HZ_W       = 32,
   parameter int             CYC_PER_US = 125,
   parameter int             SLOW_HZ    = 400000,
   parameter int             PERIODS    = 4,
   parameter int             ZERO_US    = 10,
   parameter bit             HOLD_EN    = 1'b1,
   parameter logic [ADDR_W-1:0] BSZ_OFF  = 'h04,
   parameter logic [ADDR_W-1:0] BCNT_OFF = 'h06,
   parameter logic [ADDR_W-1:0] XFER_OFF = 'h0C,
   parameter logic [ADDR_W-1:0] CMD_OFF  = 'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic              up_write,
   input  logic [1:0]        up_size,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [DATA_W-1:0] up_wdata,
   output logic [DATA_W-1:0] up_rdata,
   output logic              up_rvalid,
   input  logic [HZ_W-1:0]   card_hz,
   output logic              dn_valid,
   output logic              dn_we,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic [DATA_W-1:0] dn_rdata
);
   localparam logic [ADDR_W-1:0] BLK_WORD = {BSZ_OFF[ADDR_W-1:2], 2'b00};
   localparam logic [ADDR_W-1:0] CMD_WORD = {CMD_OFF[ADDR_W-1:2], 2'b00};

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("regwr_combiner: DATA_W must be 32");
      end
      if (CYC_PER_US < 1) begin : g_bad_cyc
         $error("regwr_combiner: CYC_PER_US must be positive");
      end
      if (BSZ_OFF[ADDR_W-1:2] != BCNT_OFF[ADDR_W-1:2] ||
          XFER_OFF[ADDR_W-1:2] != CMD_OFF[ADDR_W-1:2]) begin : g_bad_map
         $error("regwr_combiner: shadowed halfword pairs must share a word");
      end
   endgenerate

   rwc_state_e state;
   logic              req_write;
   logic [1:0]        req_size;
   logic [ADDR_W-1:0] req_addr;
   logic [DATA_W-1:0] req_wdata;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] cmd_word;
   logic              second_pend;

   logic              idle, accept, slow;
   logic              cur_write;
   logic [1:0]        cur_size;
   logic [ADDR_W-1:0] cur_addr, cur_waddr;
   logic [DATA_W-1:0] cur_wdata, base_word, merged, extracted;
   logic              is_half, hit_blk, hit_xfer, hit_cmd;
   logic [DATA_W-1:0] blk_word, cmdsh_word;
   logic              blk_valid, cmd_valid;
   logic              blk_load, blk_clear, cmd_load, cmd_clear;
   logic              hold_start, hold_busy, hold_last;

   always_comb begin
      idle      = (state == ST_IDLE);
      accept    = idle && up_valid;
      slow      = HOLD_EN && (card_hz <= HZ_W'(SLOW_HZ));
      cur_write = idle ? up_write : req_write;
      cur_size  = idle ? up_size  : req_size;
      cur_addr  = idle ? up_addr  : req_addr;
      cur_wdata = idle ? up_wdata : req_wdata;
      cur_waddr = {cur_addr[ADDR_W-1:2], 2'b00};
      is_half   = (cur_size == SZ_HALF);
      hit_blk   = is_half && (cur_addr == BSZ_OFF || cur_addr == BCNT_OFF);
      hit_xfer  = is_half && (cur_addr == XFER_OFF);
      hit_cmd   = is_half && (cur_addr == CMD_OFF);
      if (state == ST_RDW)  base_word = dn_rdata;
      else if (hit_blk)     base_word = blk_word;
      else                  base_word = cmdsh_word;

      blk_load  = (accept && cur_write && hit_blk && blk_valid) ||
                  (state == ST_RDW && cur_write && hit_blk);
      blk_clear = accept && cur_write && hit_cmd && blk_valid;
      cmd_load  = (state == ST_RDW) && cur_write && hit_xfer;
      cmd_clear = accept && cur_write && hit_cmd;
      hold_start = (state == ST_WR) && slow;

      up_ready = idle;
      dn_valid = (state == ST_RD) || (state == ST_WR);
      dn_we    = (state == ST_WR);
      dn_addr  = (state == ST_WR) ? wr_addr : cur_waddr;
      dn_wdata = wr_data;
   end

   rwc_lane #(.DATA_W(DATA_W)) u_lane (
      .old_word (base_word),
      .new_val  (cur_wdata),
      .size     (cur_size),
      .lane     (cur_addr[1:0]),
      .merged   (merged),
      .extracted(extracted)
   );

   rwc_shadow #(.DATA_W(DATA_W)) u_blk_shadow (
      .clk(clk), .rst_n(rst_n), .load(blk_load), .din(merged),
      .clear(blk_clear), .word(blk_word), .valid(blk_valid)
   );

   rwc_shadow #(.DATA_W(DATA_W)) u_cmd_shadow (
      .clk(clk), .rst_n(rst_n), .load(cmd_load), .din(merged),
      .clear(cmd_clear), .word(cmdsh_word), .valid(cmd_valid)
   );

   generate
      if (HOLD_EN) begin : g_hold
         rwc_holdoff #(
            .CYC_PER_US(CYC_PER_US), .HZ_W(HZ_W),
            .PERIODS(PERIODS), .ZERO_US(ZERO_US)
         ) u_holdoff (
            .clk(clk), .rst_n(rst_n), .start(hold_start),
            .card_hz(card_hz), .busy(hold_busy), .last(hold_last)
         );
      end else begin : g_nohold
         assign hold_busy = 1'b0;
         assign hold_last = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         req_write   <= 1'b0;
         req_size    <= SZ_WORD;
         req_addr    <= '0;
         req_wdata   <= '0;
         wr_addr     <= '0;
         wr_data     <= '0;
         cmd_word    <= '0;
         second_pend <= 1'b0;
         up_rdata    <= '0;
         up_rvalid   <= 1'b0;
      end else begin
         up_rvalid <= 1'b0;
         unique case (state)
            ST_IDLE: if (accept) begin
               req_write <= up_write;
               req_size  <= up_size;
               req_addr  <= up_addr;
               req_wdata <= up_wdata;
               if (!up_write) begin
                  if ((hit_xfer && cmd_valid) || (hit_blk && blk_valid)) begin
                     up_rdata  <= extracted;
                     up_rvalid <= 1'b1;
                  end else begin
                     state <= ST_RD;
                  end
               end else if (up_size == SZ_WORD || up_size == 2'd3) begin
                  wr_addr     <= cur_waddr;
                  wr_data     <= up_wdata;
                  second_pend <= 1'b0;
                  state       <= ST_WR;
               end else if (hit_cmd) begin
                  cmd_word <= merged;
                  state    <= ST_WR;
                  if (blk_valid) begin
                     wr_addr     <= BLK_WORD;
                     wr_data     <= blk_word;
                     second_pend <= 1'b1;
                  end else begin
                     wr_addr     <= CMD_WORD;
                     wr_data     <= merged;
                     second_pend <= 1'b0;
                  end
               end else if (!(hit_blk && blk_valid)) begin
                  state <= ST_RD;
               end
            end
            ST_RD: state <= ST_RDW;
            ST_RDW: begin
               if (!req_write) begin
                  up_rdata  <= extracted;
                  up_rvalid <= 1'b1;
                  state     <= ST_IDLE;
               end else if (hit_blk || hit_xfer) begin
                  state <= ST_IDLE;
               end else begin
                  wr_addr     <= cur_waddr;
                  wr_data     <= merged;
                  second_pend <= 1'b0;
                  state       <= ST_WR;
               end
            end
            ST_WR: begin
               if (slow) begin
                  state <= ST_HOLD;
               end else if (second_pend) begin
                  second_pend <= 1'b0;
                  wr_addr     <= CMD_WORD;
                  wr_data     <= cmd_word;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_HOLD: if (hold_last) begin
               if (second_pend) begin
                  second_pend <= 1'b0;
                  wr_addr     <= CMD_WORD;
                  wr_data     <= cmd_word;
                  state       <= ST_WR;
               end else begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_flush_to_blk_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_we && second_pend) |-> (dn_addr == BLK_WORD));
   p_flags_cleared_on_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_we && second_pend) |-> (!blk_valid && !cmd_valid));
   p_shadow_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blk_valid) |-> !(dn_valid && dn_we));
   p_stall_blocks_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hold_busy |-> !up_ready);
   p_rvalid_when_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      up_rvalid |-> up_ready);
   p_one_cycle_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (up_rvalid && !up_valid) |=> !up_rvalid);
endmodule

// File: tb/regwr_combiner_tb.sv
module regwr_combiner_tb_top;
   localparam int C = 125;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_valid = 1'b0;
   logic        up_ready;
   logic        up_write = 1'b0;
   logic [1:0]  up_size = 2'd2;
   logic [7:0]  up_addr = '0;
   logic [31:0] up_wdata = '0;
   logic [31:0] up_rdata;
   logic        up_rvalid;
   logic [31:0] card_hz = 32'd25_000_000;
   logic        dn_valid, dn_we;
   logic [7:0]  dn_addr;
   logic [31:0] dn_wdata;
   logic [31:0] dn_rdata = '0;

   logic [31:0] mem [0:63];
   int          wcnt = 0;
   int          rcnt = 0;
   logic [7:0]  wlog_a [0:1];
   logic [31:0] wlog_d [0:1];
   int          checks = 0;
   int          fails = 0;

   always #4 clk = ~clk;

   regwr_combiner #(.CYC_PER_US(C)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
      .up_size(up_size), .up_addr(up_addr), .up_wdata(up_wdata),
      .up_rdata(up_rdata), .up_rvalid(up_rvalid), .card_hz(card_hz),
      .dn_valid(dn_valid), .dn_we(dn_we), .dn_addr(dn_addr),
      .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
   );

   always @(posedge clk) begin
      if (dn_valid && dn_we) begin
         mem[dn_addr[7:2]] <= dn_wdata;
         wcnt      <= wcnt + 1;
         wlog_a[0] <= wlog_a[1];
         wlog_d[0] <= wlog_d[1];
         wlog_a[1] <= dn_addr;
         wlog_d[1] <= dn_wdata;
      end else if (dn_valid) begin
         dn_rdata <= mem[dn_addr[7:2]];
         rcnt     <= rcnt + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic access(input bit wr, input logic [1:0] sz, input logic [7:0] a,
                         input logic [31:0] d, output logic [31:0] rd,
                         output int stall);
      @(negedge clk);
      while (!up_ready) @(negedge clk);
      up_valid = 1'b1; up_write = wr; up_size = sz; up_addr = a; up_wdata = d;
      @(negedge clk);
      up_valid = 1'b0;
      stall = 0;
      while (!up_ready) begin
         stall++;
         @(negedge clk);
      end
      rd = up_rdata;
      if (!wr && !up_rvalid) begin
         checks++; fails++;
         $display("FAIL R11: actual rvalid 0 expected 1");
      end
   endtask

   task automatic wr_acc(input logic [1:0] sz, input logic [7:0] a,
                         input logic [31:0] d, output int stall);
      logic [31:0] dummy;
      access(1'b1, sz, a, d, dummy, stall);
   endtask

   task automatic rd_chk(input logic [1:0] sz, input logic [7:0] a,
                         input logic [31:0] exp, input string tag);
      logic [31:0] v;
      int s;
      access(1'b0, sz, a, '0, v, s);
      chk(v == exp, tag, v, exp);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      chk(up_ready == 1'b1, "R10 ready after reset", {31'd0, up_ready}, 32'd1);
      chk(dn_valid == 1'b0, "R10 no downstream after reset", {31'd0, dn_valid}, 32'd0);
   endtask

   task automatic t_word();
      int s; int w0;
      w0 = wcnt;
      wr_acc(2'd2, 8'h20, 32'hA5A5_A5A5, s);
      chk(s == 1, "R1 word write stall", s, 1);
      chk(wcnt == w0 + 1 && mem[8] == 32'hA5A5_A5A5, "R1 word write", mem[8], 32'hA5A5_A5A5);
      rd_chk(2'd2, 8'h20, 32'hA5A5_A5A5, "R1 word read");
   endtask

   task automatic t_narrow();
      int s;
      wr_acc(2'd0, 8'h21, 32'h3C, s);
      chk(mem[8] == 32'hA5A5_3CA5, "R2 byte merge", mem[8], 32'hA5A5_3CA5);
      rd_chk(2'd0, 8'h21, 32'h3C, "R2 byte read");
      wr_acc(2'd1, 8'h22, 32'h1234, s);
      chk(mem[8] == 32'h1234_3CA5, "R2 half merge", mem[8], 32'h1234_3CA5);
      rd_chk(2'd1, 8'h22, 32'h1234, "R2 half read");
   endtask

   task automatic t_block();
      int s; int w0; int r0;
      wr_acc(2'd2, 8'h04, 32'h1111_2222, s);
      w0 = wcnt; r0 = rcnt;
      wr_acc(2'd1, 8'h04, 32'h0200, s);
      chk(wcnt == w0, "R3 size held, no write", wcnt, w0);
      chk(mem[1] == 32'h1111_2222, "R3 word untouched", mem[1], 32'h1111_2222);
      wr_acc(2'd1, 8'h06, 32'h0008, s);
      chk(rcnt == r0 + 1, "R7 no read when shadow valid", rcnt, r0 + 1);
      chk(wcnt == w0, "R3 count held, no write", wcnt, w0);
      rd_chk(2'd1, 8'h06, 32'h0008, "R6 count from shadow");
      rd_chk(2'd1, 8'h04, 32'h0200, "R6 size from shadow");
      chk(rcnt == r0 + 1, "R6 shadow read no downstream", rcnt, r0 + 1);
      rd_chk(2'd0, 8'h04, 32'h22, "R6 byte read downstream");
   endtask

   task automatic t_xfer();
      int s; int w0;
      wr_acc(2'd2, 8'h0C, 32'hAAAA_5555, s);
      w0 = wcnt;
      wr_acc(2'd1, 8'h0C, 32'h0037, s);
      chk(wcnt == w0 && mem[3] == 32'hAAAA_5555, "R4 mode held", mem[3], 32'hAAAA_5555);
      rd_chk(2'd1, 8'h0C, 32'h0037, "R6 mode from shadow");
      rd_chk(2'd1, 8'h0E, 32'hAAAA, "R6 command read downstream");
   endtask

   task automatic t_cmd();
      int s; int w0; int r0;
      w0 = wcnt;
      wr_acc(2'd1, 8'h0E, 32'h1234, s);
      chk(s == 2, "R5 flush stall", s, 2);
      chk(wcnt == w0 + 2, "R5 two writes", wcnt, w0 + 2);
      chk(wlog_a[0] == 8'h04 && wlog_d[0] == 32'h0008_0200, "R5 first write block", wlog_d[0], 32'h0008_0200);
      chk(wlog_a[1] == 8'h0C && wlog_d[1] == 32'h1234_0037, "R5 second write command", wlog_d[1], 32'h1234_0037);
      r0 = rcnt;
      rd_chk(2'd1, 8'h04, 32'h0200, "R5 block flag cleared");
      chk(rcnt == r0 + 1, "R5 block read goes downstream", rcnt, r0 + 1);
      rd_chk(2'd1, 8'h0C, 32'h0037, "R5 mode flag cleared");
      w0 = wcnt;
      wr_acc(2'd1, 8'h0E, 32'h5555, s);
      chk(wcnt == w0 + 1 && wlog_a[1] == 8'h0C, "R5 single write no block", wcnt, w0 + 1);
      chk(wlog_d[1] == 32'h5555_0037, "R5 merge with stale mode shadow", wlog_d[1], 32'h5555_0037);
   endtask

   task automatic t_byte();
      int s; int w0;
      wr_acc(2'd1, 8'h04, 32'h0111, s);
      w0 = wcnt;
      wr_acc(2'd0, 8'h05, 32'h77, s);
      chk(wcnt == w0 + 1 && mem[1] == 32'h0008_7700, "R8 byte not shadowed", mem[1], 32'h0008_7700);
      rd_chk(2'd1, 8'h04, 32'h0111, "R8 shadow unchanged by byte");
      wr_acc(2'd1, 8'h0E, 32'h0001, s);
      chk(mem[1] == 32'h0008_0111, "R5 flush after byte", mem[1], 32'h0008_0111);
   endtask

   task automatic t_hold();
      int s;
      card_hz = 32'd400000;
      wr_acc(2'd2, 8'h30, 32'h1, s);
      chk(s == 1 + 10 * C, "R9 stall at 400 kHz", s, 1 + 10 * C);
      card_hz = 32'd300000;
      wr_acc(2'd2, 8'h30, 32'h2, s);
      chk(s == 1 + 14 * C, "R9 stall rounded up", s, 1 + 14 * C);
      card_hz = 32'd0;
      wr_acc(2'd2, 8'h30, 32'h3, s);
      chk(s == 1 + 10 * C, "R9 stall at zero clock", s, 1 + 10 * C);
      card_hz = 32'd400001;
      wr_acc(2'd2, 8'h30, 32'h4, s);
      chk(s == 1, "R9 no stall above limit", s, 1);
      card_hz = 32'd400000;
      wr_acc(2'd1, 8'h04, 32'h0040, s);
      wr_acc(2'd1, 8'h0E, 32'h0002, s);
      chk(s == 2 + 20 * C, "R9 R5 flush with two stalls", s, 2 + 20 * C);
      chk(wlog_a[0] == 8'h04 && wlog_d[0] == 32'h0008_0040, "R5 slow flush block", wlog_d[0], 32'h0008_0040);
      card_hz = 32'd25_000_000;
   endtask

   task automatic t_reset2();
      int s; int w0;
      wr_acc(2'd1, 8'h06, 32'h0099, s);
      do_reset();
      t_reset();
      rd_chk(2'd1, 8'h06, 32'h0008, "R10 block flag cleared by reset");
      w0 = wcnt;
      wr_acc(2'd1, 8'h0E, 32'h00AB, s);
      chk(wcnt == w0 + 1 && wlog_d[1] == 32'h00AB_0000, "R10 mode shadow zeroed", wlog_d[1], 32'h00AB_0000);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      wlog_a[0] = '0; wlog_a[1] = '0; wlog_d[0] = '0; wlog_d[1] = '0;
      do_reset();
      t_reset();
      t_word();
      t_narrow();
      t_block();
      t_xfer();
      t_cmd();
      t_byte();
      t_hold();
      t_reset2();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule